// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Front End

This block is the bus-facing slave logic for a 4096-byte memory that is reached over a two-wire serial bus. A fast system clock samples the serial clock and data lines. The block finds start and stop conditions, assembles bytes most significant bit first, and answers on the data line through an open-drain enable. A transaction opens with a control byte. That byte carries a fixed device code, three chip-select bits that must match strap inputs, and a read/write flag. For writes, a two-byte word address follows, and then data bytes, each stored at an internal pointer that advances by one.

Reads return the byte at the pointer. The pointer persists between transactions, so a read that follows a completed access continues from the next address. A random read is a write-mode control byte, the two address bytes, a repeated start, and then a read-mode control byte. A sequential read keeps going while the master acknowledges and stops at the master's not-acknowledge. Toward the storage, the block drives a byte write strobe and a byte read strobe with an address. A busy input from the storage side (for example, an ongoing programming cycle) makes the slave refuse to acknowledge anything.

Top module: `i2c_mem_slave`

## Requirements
- R1: A falling data line while the clock is high is a start: it aborts whatever is in progress, releases the data line and makes the next byte a control byte. A rising data line while the clock is high is a stop: it returns the block to idle and releases the data line.
- R2: A control byte whose bits 7..4 are 1010 and whose bits 3..1 equal `strap_sel[2:0]` is acknowledged: `sda_oe` is high for the whole high phase of the ninth clock. Bit 0 = 1 selects read and bit 0 = 0 selects write.
- R3: A control byte with any other code or select bits is not acknowledged. The block then leaves the data line released and causes no memory write for any byte until the next start.
- R4: After a write control byte, the first byte sets pointer bits 11..8 from its bits 3..0, and its bits 7..4 are ignored. The second byte sets pointer bits 7..0. Each further byte is written at the pointer and acknowledged, and the pointer then advances by one.
- R5: While `mem_busy` is high at the end of a byte, that byte is not acknowledged, no write occurs, and the block goes idle until the next start.
- R6: A read control byte with no address phase returns the byte at the current pointer, which after reset is 0x000 and otherwise is one past the last address accessed.
- R7: A write control byte, two address bytes, a repeated start and a read control byte return the byte at the address just given.
- R8: The pointer is 12 bits wide, advances by one after every byte transferred, and wraps from 0xFFF to 0x000. Sequential reads continue across that wrap.
- R9: A not-acknowledge from the master after a read byte ends the read. The block releases the data line and drives nothing on any later clock until the next start.
- R10: `sda_oe` never asserts while the serial clock is high. Read bits and acknowledges change only after a detected clock falling edge.
- R11: After reset, `sda_oe`, `mem_we` and `mem_re` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| strap_sel | input | 3 | Chip-select straps compared with control bits 3..1 |
| mem_addr | output | ADDR_W | Byte address toward storage (the pointer) |
| mem_wdata | output | 8 | Byte to store |
| mem_we | output | 1 | One-cycle write strobe at `mem_addr` |
| mem_re | output | 1 | One-cycle strobe marking that `mem_rdata` was taken |
| mem_rdata | input | 8 | Byte stored at `mem_addr`, valid in the same cycle |
| mem_busy | input | 1 | Storage is busy, so acknowledges are refused |

## Verification
The bench sweeps all eight select codes against a fixed strap setting and sends a wrong device code. A slave with a faulty comparator would then acknowledge a foreign device or stay deaf to its own. Writes and sequential reads are placed so they straddle 0xFFF to 0x000, which exposes a pointer that saturates or overflows into the ignored high address bits. Current-address reads right after reset and after a random read catch a pointer that is off by one or that is cleared by a new transaction. Busy is raised both at the control byte and just before a data byte, so a slave that writes or acknowledges during a programming cycle shows up. Extra clocks after a master not-acknowledge catch a slave that keeps driving data.

// File: rtl/i2c_mem_pkg.sv
// Package: shared state encoding and constants for the serial memory slave.
// Assumes byte-wide transfers on the bus.
package i2c_mem_pkg;

    localparam int          BYTE_BITS = 8;
    localparam logic [3:0]  DEV_CODE  = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL,
        ST_ADDR_HI,
        ST_ADDR_LO,
        ST_WRITE,
        ST_READ
    } slv_state_t;

endpackage

// File: rtl/i2c_line_sync.sv
// Module: i2c_line_sync
// Brings one asynchronous bus line into the clk domain through STAGES
// flops and flags its rising and falling edges one register later.
// Assumes the line is idle high, so every stage resets to 1.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o,
    output logic rise_o,
    output logic fall_o
);

    // pipe[STAGES-1] is the synchronized level, pipe[STAGES] its previous value
    logic [STAGES:0] pipe;

    // Shift the raw line through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= {(STAGES + 1){1'b1}};
        else        pipe <= {pipe[STAGES-1:0], line_i};
    end

    assign line_o = pipe[STAGES-1];
    assign rise_o = pipe[STAGES-1] & ~pipe[STAGES];
    assign fall_o = ~pipe[STAGES-1] & pipe[STAGES];

endmodule

// File: rtl/i2c_addr_ptr.sv
// Module: i2c_addr_ptr
// Holds the word address pointer. The high part and the low byte load
// separately from received address bytes, and the pointer advances by one
// with natural wrap at 2**ADDR_W. Assumes at most one request per cycle
// (load high has priority, then load low, then increment).
module i2c_addr_ptr #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_hi,
    input  logic              ld_lo,
    input  logic              inc,
    input  logic [ADDR_W-9:0] hi_val,
    input  logic [7:0]        lo_val,
    output logic [ADDR_W-1:0] ptr_o
);

    // Update the pointer from address loads or auto-increment
    always_ff @(posedge clk) begin
        if (!rst_n)     ptr_o <= '0;
        else if (ld_hi) ptr_o[ADDR_W-1:8] <= hi_val;
        else if (ld_lo) ptr_o[7:0] <= lo_val;
        else if (inc)   ptr_o <= ptr_o + 1'b1;
    end

endmodule

// File: rtl/i2c_mem_slave.sv
// Module: i2c_mem_slave
// Slave protocol engine for a byte-addressed serial memory. It detects
// start and stop, receives control and address bytes, writes data bytes
// through a strobe port, and returns read bytes on an open-drain enable.
// Assumes clk is at least about 8x faster than the serial clock and that
// mem_rdata is valid combinationally for mem_addr.
module i2c_mem_slave
    import i2c_mem_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [2:0]        strap_sel,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_busy
);

    localparam int HI_W  = ADDR_W - 8;
    localparam int CNT_W = $clog2(BYTE_BITS + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_BITS);

    // Line synchronizers: index 0 is the clock line, index 1 the data line
    logic [1:0] raw_lines, sync_lines, rise_lines, fall_lines;
    assign raw_lines = {sda_i, scl_i};

    for (genvar gi = 0; gi < 2; gi++) begin : g_sync
        i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw_lines[gi]),
            .line_o (sync_lines[gi]),
            .rise_o (rise_lines[gi]),
            .fall_o (fall_lines[gi])
        );
    end

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    assign scl_s     = sync_lines[0];
    assign sda_s     = sync_lines[1];
    assign scl_rise  = rise_lines[0];
    assign scl_fall  = fall_lines[0];
    assign start_det = fall_lines[1] & scl_s;
    assign stop_det  = rise_lines[1] & scl_s;

    slv_state_t       state;
    logic [CNT_W-1:0] bit_cnt;
    logic             in_ack;
    logic             ack_bit;
    logic [7:0]       shreg;
    logic [7:0]       tx;
    logic             ptr_ld_hi, ptr_ld_lo, ptr_inc;

    // Acceptance of the byte just received
    logic ctrl_match, ack_ok;
    assign ctrl_match = (shreg[7:4] == DEV_CODE) && (shreg[3:1] == strap_sel);
    assign ack_ok     = !mem_busy && ((state != ST_CTRL) || ctrl_match);

    i2c_addr_ptr #(.ADDR_W(ADDR_W)) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld_hi  (ptr_ld_hi),
        .ld_lo  (ptr_ld_lo),
        .inc    (ptr_inc),
        .hi_val (shreg[HI_W-1:0]),
        .lo_val (shreg),
        .ptr_o  (mem_addr)
    );

    // Protocol sequencer: bit counting, acknowledge slots and strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            bit_cnt   <= '0;
            in_ack    <= 1'b0;
            ack_bit   <= 1'b1;
            shreg     <= '0;
            tx        <= '0;
            sda_oe    <= 1'b0;
            mem_we    <= 1'b0;
            mem_re    <= 1'b0;
            mem_wdata <= '0;
            ptr_ld_hi <= 1'b0;
            ptr_ld_lo <= 1'b0;
            ptr_inc   <= 1'b0;
        end else begin
            mem_we    <= 1'b0;
            mem_re    <= 1'b0;
            ptr_ld_hi <= 1'b0;
            ptr_ld_lo <= 1'b0;
            ptr_inc   <= 1'b0;
            if (start_det) begin
                state   <= ST_CTRL;
                bit_cnt <= '0;
                in_ack  <= 1'b0;
                sda_oe  <= 1'b0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                in_ack <= 1'b0;
                sda_oe <= 1'b0;
            end else if (state != ST_IDLE) begin
                if (scl_rise) begin
                    if (in_ack) begin
                        ack_bit <= sda_s;
                    end else if (bit_cnt != LAST_BIT) begin
                        shreg   <= {shreg[6:0], sda_s};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end else if (scl_fall) begin
                    if (in_ack) begin
                        // End of the ninth clock: next byte or stop reading
                        in_ack  <= 1'b0;
                        bit_cnt <= '0;
                        sda_oe  <= 1'b0;
                        if (state == ST_READ) begin
                            if (ack_bit) begin
                                state <= ST_IDLE;
                            end else begin
                                tx      <= mem_rdata;
                                mem_re  <= 1'b1;
                                ptr_inc <= 1'b1;
                                sda_oe  <= ~mem_rdata[7];
                            end
                        end
                    end else if (bit_cnt == LAST_BIT) begin
                        // Start of the ninth clock: decide on acknowledge
                        in_ack <= 1'b1;
                        if (state == ST_READ) begin
                            sda_oe <= 1'b0;
                        end else if (!ack_ok) begin
                            state  <= ST_IDLE;
                            sda_oe <= 1'b0;
                        end else begin
                            sda_oe <= 1'b1;
                            unique case (state)
                                ST_CTRL:    state <= shreg[0] ? ST_READ : ST_ADDR_HI;
                                ST_ADDR_HI: begin
                                    ptr_ld_hi <= 1'b1;
                                    state     <= ST_ADDR_LO;
                                end
                                ST_ADDR_LO: begin
                                    ptr_ld_lo <= 1'b1;
                                    state     <= ST_WRITE;
                                end
                                ST_WRITE: begin
                                    mem_we    <= 1'b1;
                                    mem_wdata <= shreg;
                                    ptr_inc   <= 1'b1;
                                end
                                default: state <= ST_IDLE;
                            endcase
                        end
                    end else if (state == ST_READ) begin
                        sda_oe <= ~tx[3'(4'd7 - 4'(bit_cnt))];
                    end
                end
            end
        end
    end

endmodule

// File: rtl/i2c_mem_slave_chk.sv
// Module: i2c_mem_slave_chk
// Property checker for i2c_mem_slave, attached through bind. Watches the
// synchronized clock line, the condition detectors, the pointer and the
// storage strobes.
module i2c_mem_slave_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_s,
    input logic              start_det,
    input logic              stop_det,
    input logic              sda_oe,
    input logic              mem_we,
    input logic              mem_re,
    input logic              mem_busy,
    input logic              ptr_inc,
    input logic [ADDR_W-1:0] mem_addr
);

    // R1: a start releases the data line on the next cycle
    assert_start_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe);

    // R1: a stop releases the data line on the next cycle
    assert_stop_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    // R5: no store follows a cycle in which storage reported busy
    assert_no_write_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !$past(mem_busy));

    // R4: a stored byte is acknowledged in the same slot
    assert_write_acked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> sda_oe);

    // R8: the pointer wraps from all ones to zero
    assert_ptr_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ptr_inc) && ($past(mem_addr) == {ADDR_W{1'b1}})) |-> (mem_addr == '0));

    // R10: the data drive holds steady through a clock high phase
    assert_oe_steady_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s) && !$past(start_det) && !$past(stop_det)) |-> $stable(sda_oe));

    // R4: read and write strobes never coincide
    assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

endmodule

bind i2c_mem_slave i2c_mem_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_oe    (sda_oe),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .mem_busy  (mem_busy),
    .ptr_inc   (ptr_inc),
    .mem_addr  (mem_addr)
);

// File: tb/sim_i2c_mem_slave.sv
// Bench: drives a bus master model against i2c_mem_slave with a 4096-byte
// storage model, and checks acknowledges, stored bytes and read bytes
// against values computed here.
module sim_i2c_mem_slave;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 10;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [7:0] CW = {4'b1010, STRAP, 1'b0};
    localparam logic [7:0] CR = {4'b1010, STRAP, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic busy = 1'b0;

    logic        sda_oe, mem_we, mem_re;
    logic [11:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    wire         sda_line = sda_m & ~sda_oe;

    logic [7:0] mem [0:4095];
    int we_count = 0;
    int errors = 0;
    int checks = 0;
    int viol = 0;
    int hi_cnt = 0;
    logic prev_oe = 1'b0;

    // Writes the bench itself expects, newest last
    logic [11:0] wr_a [0:7];
    logic [7:0]  wr_d [0:7];
    int wr_n = 0;

    i2c_mem_slave u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_m),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .strap_sel (STRAP),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_re    (mem_re),
        .mem_rdata (mem_rdata),
        .mem_busy  (busy)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [7:0] init_byte(input int a);
        return 8'((a * 7 + 3) ^ (a >> 8));
    endfunction

    function automatic logic [7:0] exp_byte(input int a);
        logic [7:0] v = init_byte(a);
        for (int i = 0; i < wr_n; i++)
            if (int'(wr_a[i]) == a) v = wr_d[i];
        return v;
    endfunction

    assign mem_rdata = mem[mem_addr];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4096; i++) mem[i] <= init_byte(i);
        end else if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
            we_count <= we_count + 1;
        end
    end

    // Monitor for R10: drive must not assert deep inside a clock high phase
    always @(negedge clk) begin
        if (scl_m) hi_cnt = hi_cnt + 1;
        else       hi_cnt = 0;
        if (rst_n && hi_cnt > 4 && sda_oe && !prev_oe) viol = viol + 1;
        prev_oe = sda_oe;
    end

    task automatic chk(input int act, input int expv, input string tag);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic bus_start();
        wq(Q); sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(2 * Q);
        sda_m = 1'b0; wq(2 * Q); scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(2 * Q);
        sda_m = 1'b1; wq(2 * Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            wq(Q); sda_m = b[i]; wq(Q); scl_m = 1'b1; wq(2 * Q); scl_m = 1'b0;
        end
        wq(Q); sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
        @(negedge clk); acked = (sda_line == 1'b0);
        wq(Q); scl_m = 1'b0;
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] b);
        b = '0;
        for (int i = 0; i < 8; i++) begin
            wq(Q); sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
            @(negedge clk); b = {b[6:0], sda_line};
            wq(Q); scl_m = 1'b0;
        end
        wq(Q); sda_m = nack; wq(Q); scl_m = 1'b1; wq(2 * Q); scl_m = 1'b0;
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=0", 1);
        report();
        $finish;
    end

    initial begin
        logic ack;
        logic [7:0] rb;
        logic [7:0] wd [0:3];
        int base_we;
        wd[0] = 8'h5A; wd[1] = 8'hC3; wd[2] = 8'h0F; wd[3] = 8'h99;

        wq(5);
        @(negedge clk);
        chk(int'(sda_oe), 0, "R11 sda_oe after reset");
        chk(int'(mem_we), 0, "R11 mem_we after reset");
        chk(int'(mem_re), 0, "R11 mem_re after reset");
        rst_n = 1'b1;
        wq(5);

        // R6: current-address read from the reset pointer
        bus_start(); send_byte(CR, ack);
        chk(int'(ack), 1, "R2 read control ack");
        recv_byte(1'b1, rb);
        chk(int'(rb), int'(exp_byte(0)), "R6 current read at 0x000");
        bus_stop();

        // R2/R3: sweep every select code against the strap
        for (int a = 0; a < 8; a++) begin
            bus_start(); send_byte({4'b1010, 3'(a), 1'b0}, ack);
            chk(int'(ack), (a == int'(STRAP)) ? 1 : 0, "R2 R3 select sweep");
            bus_stop();
        end

        // R3: wrong device code, later bytes ignored
        base_we = we_count;
        bus_start(); send_byte({4'b1011, STRAP, 1'b0}, ack);
        chk(int'(ack), 0, "R3 wrong code no ack");
        send_byte(8'h00, ack);
        chk(int'(ack), 0, "R3 following byte ignored");
        send_byte(8'h11, ack);
        chk(we_count - base_we, 0, "R3 no write after mismatch");
        bus_stop();

        // R4/R8: page write across the top address, high nibble ignored
        bus_start(); send_byte(CW, ack);
        send_byte(8'hFF, ack); chk(int'(ack), 1, "R4 addr hi ack");
        send_byte(8'hFE, ack); chk(int'(ack), 1, "R4 addr lo ack");
        for (int i = 0; i < 4; i++) begin
            send_byte(wd[i], ack);
            chk(int'(ack), 1, "R4 data ack");
            wr_a[wr_n] = 12'(12'hFFE + i); wr_d[wr_n] = wd[i]; wr_n++;
        end
        bus_stop();
        for (int i = 0; i < 4; i++)
            chk(int'(mem[12'(12'hFFE + i)]), int'(wd[i]), "R4 R8 stored byte");

        // R7/R8/R9: random read from 0xFFD across the wrap
        bus_start(); send_byte(CW, ack);
        send_byte(8'h0F, ack); send_byte(8'hFD, ack);
        bus_start(); send_byte(CR, ack);
        chk(int'(ack), 1, "R7 restart read ack");
        for (int i = 0; i < 5; i++) begin
            recv_byte(i == 4, rb);
            chk(int'(rb), int'(exp_byte(int'(12'(12'hFFD + i)))), "R7 R8 read byte");
        end
        @(negedge clk);
        chk(int'(sda_oe), 0, "R9 released after nack");
        recv_byte(1'b1, rb);
        chk(int'(rb), 8'hFF, "R9 no drive after nack");
        bus_stop();

        // R6: current read continues after the random read
        bus_start(); send_byte(CR, ack);
        recv_byte(1'b1, rb);
        chk(int'(rb), int'(exp_byte(2)), "R6 current read at 0x002");
        bus_stop();

        // R5: busy at the control byte
        busy = 1'b1;
        bus_start(); send_byte(CW, ack);
        chk(int'(ack), 0, "R5 busy control no ack");
        bus_stop();
        busy = 1'b0;

        // R5: busy raised just before a data byte
        base_we = we_count;
        bus_start(); send_byte(CW, ack);
        send_byte(8'h01, ack); send_byte(8'h23, ack);
        busy = 1'b1;
        send_byte(8'hE7, ack);
        chk(int'(ack), 0, "R5 busy data no ack");
        bus_stop();
        busy = 1'b0;
        chk(we_count - base_we, 0, "R5 no write while busy");
        chk(int'(mem[12'h123]), int'(init_byte(12'h123)), "R5 byte unchanged");

        // R8: sequential sweep of 16 bytes over the wrap
        bus_start(); send_byte(CW, ack);
        send_byte(8'h0F, ack); send_byte(8'hF8, ack);
        bus_start(); send_byte(CR, ack);
        for (int i = 0; i < 16; i++) begin
            recv_byte(i == 15, rb);
            chk(int'(rb), int'(exp_byte(int'(12'(12'hFF8 + i)))), "R8 sequential sweep");
        end
        bus_stop();

        // R1: a start in mid-byte aborts and restarts with a control byte
        bus_start(); send_byte(CW, ack);
        wq(Q); sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(2 * Q); scl_m = 1'b0;
        bus_start(); send_byte(CR, ack);
        chk(int'(ack), 1, "R1 restart mid-byte ack");
        recv_byte(1'b1, rb);
        chk(int'(rb), int'(exp_byte(8)), "R1 read after abort");
        bus_stop();
        @(negedge clk);
        chk(int'(sda_oe), 0, "R1 released after stop");

        chk(viol, 0, "R10 drive asserted during clock high");
        report();
        $finish;
    end

endmodule